// File: doc/BRIEF.md
# Peripheral and Hinted Clock Gating Controller

This block decides, cycle by cycle, which gated clocks on a chip may run. It serves two groups of consumers. Four peripheral clock domains (index 0 for the USB clock, 1 for the io clock, 2 for io divided by two, 3 for io divided by four) each carry one software enable bit. Four transactional units share the main clock; each unit has a software hint bit and reports whether it is idle. Each output is an enable meant for a clock-gate cell. The gate cells, clock generation and the register bus are outside the block.

A global enable from the power manager must be high before any gated clock runs. The enable, the software bits and the hints cross into each target domain through a two-flop synchronizer clocked by that domain. A transactional unit's clock runs when its hint is set or when it reports busy. A multi-bit scan-mode code forces every clock on, but only when it carries the exact On pattern. Per-unit hint status reports whether each unit's clock is actually running. A single clock-status bit, kept in the power-manager domain, rises once every gated clock is on and falls once every gated clock is off. In any other state it keeps its value.

Top module: `clkgate_ctrl`

## Requirements
- R1: A peripheral gate enable equals the global enable AND that domain's software bit, both taken through a two-flop synchronizer. A change on those inputs shows at the output after exactly two rising edges of the domain clock, and not after one.
- R2: While the synchronized global enable is 0 and scan mode is not active, every peripheral and unit gate enable is 0, whatever the software bits, hints and idle inputs are.
- R3: With the synchronized global enable at 1, a unit's gate enable is 1 when its synchronized hint is 1 or its idle input (1 = idle) is 0.
- R4: With the synchronized global enable at 1, a unit whose synchronized hint is 0 and whose idle input is 1 has its gate enable at 0.
- R5: When `scan_code_i` equals 4'b1010, every gate enable is 1 at once, without waiting for the synchronizers. Any other code, including a pattern one bit away from it, has no effect.
- R6: Each bit of `hint_status_o` equals the gate enable of the same unit.
- R7: `clk_status_o` becomes 1 three control-clock edges after all eight gate enables are seen at 1.
- R8: `clk_status_o` becomes 0 three control-clock edges after all eight gate enables are seen at 0. With a mix of on and off enables it keeps its last value.
- R9: Every synchronizer flop and the status flop clear to 0 on the active-low reset of its domain. Right after reset every gate enable, every hint-status bit and `clk_status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Power-manager domain clock; clocks the status path |
| rst_ctl_n | input | 1 | Active-low reset of the power-manager domain |
| clk_peri | input | 4 | Clock of each peripheral domain |
| rst_peri_n | input | 4 | Active-low reset of each peripheral domain |
| clk_main | input | 1 | Clock of the transactional units |
| rst_main_n | input | 1 | Active-low reset of the main domain |
| pwr_clk_en_i | input | 1 | Global gated-clock enable from the power manager |
| scan_code_i | input | 4 | Scan-mode code; 4'b1010 means On |
| peri_sw_en_i | input | 4 | Software enable per peripheral domain |
| unit_hint_i | input | 4 | Software hint per unit (1 = keep running) |
| unit_idle_i | input | 4 | Idle flag per unit, in the main domain (1 = idle) |
| peri_gate_en_o | output | 4 | Gate enable per peripheral domain |
| unit_gate_en_o | output | 4 | Gate enable per transactional unit |
| hint_status_o | output | 4 | Per-unit flag: the unit's clock is running |
| clk_status_o | output | 1 | Aggregate status: 1 all on, 0 all off, else held |

## Verification
The assertions assume that the idle inputs already belong to the main clock domain and that the scan code is a static test setting. For that reason both act on the gates without a synchronizer. The status assertions also assume that every gate state lasts at least one control-clock edge. The bench drives every clock from one 200 MHz source and changes all inputs on the falling edge, so each input value is sampled cleanly. Its reference model therefore follows both the short state before the synchronizers update and the settled state that comes after.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  function automatic logic peri_runs(input logic pwr, input logic sw_en);
    return pwr & sw_en;
  endfunction

  function automatic logic unit_runs(input logic pwr, input logic hint, input logic idle);
    return pwr & (hint | ~idle);
  endfunction

  function automatic logic status_next(input logic cur, input logic all_on, input logic all_off);
    if (all_on)  return 1'b1;
    if (all_off) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/clkgate_sync2.sv
module clkgate_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // R9: output is clear on the first edge after reset release
  a_r9_sync_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> (q == '0));

endmodule

// File: rtl/clkgate_peri_dom.sv
module clkgate_peri_dom
  import clkgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic sw_en,
  input  logic scan_on,
  output logic gate_en
);
  logic [1:0] synced;
  logic       pwr_q;
  logic       en_q;

  clkgate_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pwr_en, sw_en}),
    .q    (synced)
  );

  assign pwr_q   = synced[1];
  assign en_q    = synced[0];
  assign gate_en = scan_on | peri_runs(pwr_q, en_q);

  // R2: outside scan, a running gate needs the global enable two edges ago
  a_r2_pwr_required: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !scan_on) |-> $past(pwr_en, 2));

  // R1: both inputs high two edges ago (no reset since) turns the gate on
  a_r1_two_edge_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && $past(pwr_en, 2) && $past(sw_en, 2)) |-> gate_en);

endmodule

// File: rtl/clkgate_unit_dom.sv
module clkgate_unit_dom
  import clkgate_pkg::*;
#(
  parameter int NUM_UNIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_en,
  input  logic [NUM_UNIT-1:0] hint,
  input  logic [NUM_UNIT-1:0] idle,
  input  logic                scan_on,
  output logic [NUM_UNIT-1:0] gate_en
);
  localparam int SW = NUM_UNIT + 1;

  logic [SW-1:0]       synced;
  logic                pwr_q;
  logic [NUM_UNIT-1:0] hint_q;

  clkgate_sync2 #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pwr_en, hint}),
    .q    (synced)
  );

  assign pwr_q  = synced[SW-1];
  assign hint_q = synced[NUM_UNIT-1:0];

  for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
    assign gate_en[u] = scan_on | unit_runs(pwr_q, hint_q[u], idle[u]);

    // R3: a busy unit under global enable always runs
    a_r3_busy_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q && !idle[u]) |-> gate_en[u]);

    // R4: idle and unhinted outside scan means gated off
    a_r4_idle_unhinted_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_on && idle[u] && !hint_q[u]) |-> !gate_en[u]);
  end

endmodule

// File: rtl/clkgate_status.sv
module clkgate_status
  import clkgate_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gates,
  output logic         status
);
  logic [W-1:0] gates_q;
  logic         all_on;
  logic         all_off;

  clkgate_sync2 #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gates),
    .q    (gates_q)
  );

  assign all_on  = &gates_q;
  assign all_off = ~|gates_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= status_next(status, all_on, all_off);
  end

  // R7: all seen on sets the status
  a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    all_on |=> status);

  // R8: all seen off clears the status
  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |=> !status);

  // R8: mixed state keeps the status
  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_on && !all_off) |=> $stable(status));

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int              NUM_PERI = 4,
  parameter int              NUM_UNIT = 4,
  parameter int              SCAN_W   = 4,
  parameter logic [SCAN_W-1:0] SCAN_ON = 4'b1010
) (
  input  logic                clk_ctl,
  input  logic                rst_ctl_n,
  input  logic [NUM_PERI-1:0] clk_peri,
  input  logic [NUM_PERI-1:0] rst_peri_n,
  input  logic                clk_main,
  input  logic                rst_main_n,
  input  logic                pwr_clk_en_i,
  input  logic [SCAN_W-1:0]   scan_code_i,
  input  logic [NUM_PERI-1:0] peri_sw_en_i,
  input  logic [NUM_UNIT-1:0] unit_hint_i,
  input  logic [NUM_UNIT-1:0] unit_idle_i,
  output logic [NUM_PERI-1:0] peri_gate_en_o,
  output logic [NUM_UNIT-1:0] unit_gate_en_o,
  output logic [NUM_UNIT-1:0] hint_status_o,
  output logic                clk_status_o
);
  localparam int NUM_GATES = NUM_PERI + NUM_UNIT;

  logic scan_on;
  assign scan_on = (scan_code_i == SCAN_ON);

  for (genvar p = 0; p < NUM_PERI; p++) begin : g_peri
    clkgate_peri_dom u_peri (
      .clk    (clk_peri[p]),
      .rst_n  (rst_peri_n[p]),
      .pwr_en (pwr_clk_en_i),
      .sw_en  (peri_sw_en_i[p]),
      .scan_on(scan_on),
      .gate_en(peri_gate_en_o[p])
    );
  end

  clkgate_unit_dom #(.NUM_UNIT(NUM_UNIT)) u_units (
    .clk    (clk_main),
    .rst_n  (rst_main_n),
    .pwr_en (pwr_clk_en_i),
    .hint   (unit_hint_i),
    .idle   (unit_idle_i),
    .scan_on(scan_on),
    .gate_en(unit_gate_en_o)
  );

  assign hint_status_o = unit_gate_en_o;

  clkgate_status #(.W(NUM_GATES)) u_status (
    .clk   (clk_ctl),
    .rst_n (rst_ctl_n),
    .gates ({unit_gate_en_o, peri_gate_en_o}),
    .status(clk_status_o)
  );

  // R5: exact scan code forces every gate on
  a_r5_scan_all_on: assert property (@(posedge clk_ctl) disable iff (!rst_ctl_n)
    (scan_code_i == SCAN_ON) |-> ((&peri_gate_en_o) && (&unit_gate_en_o)));

endmodule

// File: tb/clkgate_ctrl_tb_top.sv
module clkgate_ctrl_tb_top;
  localparam logic [3:0] ON_CODE = 4'b1010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr;
  logic [3:0] scan;
  logic [3:0] sw_en, hint, idle;
  logic [3:0] peri_g, unit_g, hstat;
  logic       status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  clkgate_ctrl dut_i (
    .clk_ctl       (clk),
    .rst_ctl_n     (rst_n),
    .clk_peri      ({4{clk}}),
    .rst_peri_n    ({4{rst_n}}),
    .clk_main      (clk),
    .rst_main_n    (rst_n),
    .pwr_clk_en_i  (pwr),
    .scan_code_i   (scan),
    .peri_sw_en_i  (sw_en),
    .unit_hint_i   (hint),
    .unit_idle_i   (idle),
    .peri_gate_en_o(peri_g),
    .unit_gate_en_o(unit_g),
    .hint_status_o (hstat),
    .clk_status_o  (status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference: peripheral gates
  function automatic logic [3:0] ref_peri(input logic p, input logic [3:0] e, input logic [3:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (s == ON_CODE) ? 1'b1 : (p ? e[i] : 1'b0);
    return r;
  endfunction

  // reference: unit gates
  function automatic logic [3:0] ref_unit(input logic p, input logic [3:0] h, input logic [3:0] d,
                                          input logic [3:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      if (s == ON_CODE)      r[i] = 1'b1;
      else if (!p)           r[i] = 1'b0;
      else if (h[i] || !d[i]) r[i] = 1'b1;
      else                   r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic ref_status(input logic cur, input logic [7:0] g);
    if (g == 8'hFF) return 1'b1;
    if (g == 8'h00) return 1'b0;
    return cur;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic        exp_st;
    logic        o_pwr;
    logic [3:0]  o_en, o_hint;
    logic [7:0]  gb, gc;

    pwr = 0; scan = 4'h0; sw_en = 0; hint = 0; idle = 4'hF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    // R9: reset state
    chk("R9 peri gates after reset", 32'(peri_g), 0);
    chk("R9 unit gates after reset", 32'(unit_g), 0);
    chk("R9 hint status after reset", 32'(hstat), 0);
    chk("R9 status after reset", 32'(status), 0);

    // R1: latency, two edges and not one
    pwr = 1; sw_en = 4'b0110;
    settle(1);
    chk("R1 unchanged after one edge", 32'(peri_g), 0);
    settle(1);
    chk("R1 changed after two edges", 32'(peri_g), 32'h6);

    // R2: global enable off gates everything despite enables and busy units
    sw_en = 4'hF; hint = 4'hF; idle = 4'h0; pwr = 0;
    settle(2);
    chk("R2 peri off without global enable", 32'(peri_g), 0);
    chk("R2 units off without global enable", 32'(unit_g), 0);

    // R5: near-miss code does nothing, exact code forces all on immediately
    scan = 4'b1011;
    #1;
    chk("R5 near-miss scan code ignored", 32'({unit_g, peri_g}), 0);
    scan = ON_CODE;
    #1;
    chk("R5 exact scan code forces on", 32'({unit_g, peri_g}), 32'hFF);
    settle(5);
    chk("R7 status set in scan", 32'(status), 1);
    scan = 4'h0;
    settle(5);
    chk("R8 status cleared when all off", 32'(status), 0);

    // R4 / R3: idle unhinted units off, busy ones on; peris on -> mixed holds
    pwr = 1; hint = 4'b0001; idle = 4'b1101; sw_en = 4'hF;
    settle(2);
    chk("R4 idle unhinted units gated", 32'(unit_g), 32'h3);
    chk("R3 busy or hinted units run", 32'(unit_g & 4'b0011), 32'h3);
    chk("R6 hint status follows gates", 32'(hstat), 32'h3);
    settle(4);
    chk("R8 mixed holds status", 32'(status), 0);
    hint = 4'hF;
    settle(6);
    chk("R7 status set when all on", 32'(status), 1);
    exp_st = 1'b1;

    // random phase
    for (int it = 0; it < 300; it++) begin
      o_pwr = pwr; o_en = sw_en; o_hint = hint;
      pwr   = ($urandom % 4) != 0;
      sw_en = 4'($urandom);
      hint  = 4'($urandom);
      idle  = 4'($urandom);
      scan  = (($urandom % 4) == 0) ? ON_CODE : 4'($urandom);
      if (($urandom % 5) == 0) begin sw_en = 4'hF; hint = 4'hF; pwr = 1; end
      if (($urandom % 6) == 0) begin sw_en = 4'h0; hint = 4'h0; idle = 4'hF; end
      gb = {ref_unit(o_pwr, o_hint, idle, scan), ref_peri(o_pwr, o_en, scan)};
      gc = {ref_unit(pwr, hint, idle, scan), ref_peri(pwr, sw_en, scan)};
      exp_st = ref_status(ref_status(exp_st, gb), gc);
      settle(2);
      chk("R1 R2 R5 random peri gates", 32'(peri_g), 32'(gc[3:0]));
      chk("R3 R4 R5 random unit gates", 32'(unit_g), 32'(gc[7:4]));
      chk("R6 random hint status", 32'(hstat), 32'(gc[7:4]));
      settle(4);
      chk("R7 R8 random status", 32'(status), 32'(exp_st));
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule